// File: doc/BRIEF.md
# Host-Acknowledged Priority Interrupt Controller

This block gathers a vector of peripheral request lines and presents one interrupt line to a host processor. Each line is configured as edge- or level-sensitive. Rising edges on edge lines are remembered in a pending register. Level lines are used directly, because the peripheral is expected to keep its line high until software services it. Among the unmasked active lines, the one with the highest programmed priority is chosen and its index is published in a source-number register.

The host works through a fixed handshake. It reads the source number, and that read clears the pending bit of an edge source while the interrupt output stays high. It then writes the agreement bit in the control register. Only that write lowers the interrupt output. The controller then re-runs arbitration over whatever requests are still active. While the output is high, the published number is frozen, even if new events arrive.

Top module: `host_ack_intc`

## Requirements
- R1: After synchronous reset, irq is 0, the source number (address 0) reads 0, the pending vector (address 4) reads 0, all lines are masked (address 2 reads all ones) and all lines are level-sensitive.
- R2: On a line whose sensitivity bit (address 3, 1 = edge) is set, a 0-to-1 transition sets its pending bit, even when the line is masked.
- R3: A level-sensitive line never sets a pending bit, and it counts as a request for as long as its input is high.
- R4: When irq is low and the agreement bit is clear, an unmasked request raises irq on the next clock edge, and the same edge loads the source number.
- R5: The winner is the request with the largest priority value; priorities are packed into address 5 with line i at bits [i*PRIO_W +: PRIO_W]. Equal values go to the lower line index.
- R6: A line whose mask bit (address 2, 1 = masked) is set takes no part in arbitration and cannot raise irq.
- R7: A read of address 0 while irq is high returns the published index and clears that line's pending bit if it is edge-sensitive; irq stays high.
- R8: irq falls only on a write to address 1 with bit 0 set. That agreement bit reads back as 1 in the cycle after the write and as 0 afterwards.
- R9: irq is low for two cycles after the agreement write. If any request remains, irq rises on the second edge after the write, carrying the new winner.
- R10: While irq is high, the source number does not change, even if new edges are latched.
- R11: Reads return data one cycle after the read strobe. Writes to address 2 set the mask, to address 3 the sensitivity, to address 5 the priorities. Address 4 is the read-only pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Peripheral request lines, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request to the host |

## Verification
The assertions assume that the request lines are already synchronous to clk, and that the read and write strobes are never raised together. The stimulus changes all inputs on the falling edge, and it issues one register access per cycle. Before it unmasks lines, it sets up simultaneous requests under a full mask. This makes the tie-break and priority cases begin from a known pending set, rather than depending on which edge reached the arbiter first.

// File: rtl/hai_pkg.sv
package hai_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRC   = 3'd0,
    REG_CTRL  = 3'd1,
    REG_MASK  = 3'd2,
    REG_SENSE = 3'd3,
    REG_PEND  = 3'd4,
    REG_PRIO  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/hai_edge_latch.sv
module hai_edge_latch #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] line_in,
  input  logic [NUM_SRC-1:0] edge_sel,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    assign rise[i] = line_in[i] & ~prev_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i] <= 1'b0;
        pend[i]   <= 1'b0;
      end else begin
        prev_q[i] <= line_in[i];
        pend[i]   <= edge_sel[i] & (rise[i] | (pend[i] & ~clr[i]));
      end
    end

    // R2
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_sel[i] && line_in[i] && !prev_q[i]) |=> pend[i]);

    // R3
    level_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
      !edge_sel[i] |=> !pend[i]);
  end
endmodule

// File: rtl/hai_prio_pick.sv
module hai_prio_pick #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      win_valid,
  output logic [IDX_W-1:0]          win_idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best      = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!win_valid || prio[i*PRIO_W +: PRIO_W] > best)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best      = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/host_ack_intc.sv
module host_ack_intc
  import hai_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   src_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq
);
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int PRIO_BITS = NUM_SRC * PRIO_W;

  logic [NUM_SRC-1:0]   mask_q, sense_q, pend, clr_vec, req;
  logic [PRIO_BITS-1:0] prio_q;
  logic                 irq_q, agree_q;
  logic [IDX_W-1:0]     src_q, win_idx;
  logic                 win_valid, agree_wr, src_rd;

  assign agree_wr = bus_wr && (bus_addr == REG_CTRL) && bus_wdata[0];
  assign src_rd   = bus_rd && (bus_addr == REG_SRC);
  assign clr_vec  = (src_rd && irq_q) ? (NUM_SRC'(1) << src_q) : '0;
  assign req      = ~mask_q & ((pend & sense_q) | (src_in & ~sense_q));
  assign irq      = irq_q;

  hai_edge_latch #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst(rst), .line_in(src_in), .edge_sel(sense_q),
    .clr(clr_vec), .pend(pend)
  );

  hai_prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
    .req(req), .prio(prio_q), .win_valid(win_valid), .win_idx(win_idx)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      sense_q <= '0;
      prio_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        REG_MASK:  mask_q  <= bus_wdata[NUM_SRC-1:0];
        REG_SENSE: sense_q <= bus_wdata[NUM_SRC-1:0];
        REG_PRIO:  prio_q  <= bus_wdata[PRIO_BITS-1:0];
        default: ;
      endcase
    end
  end

  // host handshake: raise, freeze, drop on agreement, re-arm
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      agree_q <= 1'b0;
      src_q   <= '0;
    end else begin
      agree_q <= agree_wr;
      if (agree_wr) begin
        irq_q <= 1'b0;
      end else if (!irq_q && !agree_q && win_valid) begin
        irq_q <= 1'b1;
        src_q <= win_idx;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        REG_SRC:   bus_rdata <= DATA_W'(src_q);
        REG_CTRL:  bus_rdata <= DATA_W'(agree_q);
        REG_MASK:  bus_rdata <= DATA_W'(mask_q);
        REG_SENSE: bus_rdata <= DATA_W'(sense_q);
        REG_PEND:  bus_rdata <= DATA_W'(pend);
        REG_PRIO:  bus_rdata <= DATA_W'(prio_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> $past(agree_wr));

  // R8
  agree_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    agree_q |=> !agree_q);

  // R9
  rearm_gap_chk: assert property (@(posedge clk) disable iff (rst)
    agree_q |-> !irq_q);

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(win_valid && !agree_q));

  // R10
  src_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && $past(irq_q)) |-> $stable(src_q));

  // R6
  winner_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !mask_q[win_idx]);
endmodule

// File: tb/host_ack_intc_bench.sv
`timescale 1ns/1ps
module host_ack_intc_bench;
  localparam int N  = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_in = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [DW-1:0] exp_val[$];
  string         exp_tag[$];

  always #2 clk = ~clk;

  host_ack_intc #(.NUM_SRC(N), .PRIO_W(3), .DATA_W(DW)) u_host_ack_intc (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data once the registered result appears
  always @(posedge clk) begin
    if (bus_rd) begin
      #1;
      if (exp_val.size() > 0) check(exp_tag.pop_front(), bus_rdata, exp_val.pop_front());
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    exp_val.push_back(e); exp_tag.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_in = src_in | m;
    @(negedge clk);
    src_in = src_in & ~m;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", irq, 0);
    bus_read(3'd0, 0, "R1 source number");
    bus_read(3'd2, 8'hFF, "R1 mask");
    bus_read(3'd4, 0, "R1 pending");

    // lines 0-3 edge, 4-7 level; priorities 1:3 2:5 3:7 5:5
    bus_write(3'd3, 32'h0F);
    bus_write(3'd5, (32'd3 << 3) | (32'd5 << 6) | (32'd7 << 9) | (32'd5 << 15));
    bus_read(3'd5, (32'd3 << 3) | (32'd5 << 6) | (32'd7 << 9) | (32'd5 << 15), "R11 prio readback");

    pulse(8'h44);
    idle(1);
    bus_read(3'd4, 32'h04, "R2 R3 masked edge latched, level not");
    check("R6 masked lines keep irq low", irq, 0);

    bus_write(3'd2, 32'hFB);
    check("R4 irq not yet", irq, 0);
    idle(1);
    check("R4 irq raised", irq, 1);
    bus_read(3'd0, 2, "R4 source number");
    check("R7 irq held after read", irq, 1);
    bus_read(3'd4, 0, "R7 pending cleared");
    idle(3);
    check("R8 irq held without agreement", irq, 1);
    bus_write(3'd1, 1);
    check("R8 irq dropped", irq, 0);
    bus_read(3'd1, 1, "R8 agreement bit set");
    bus_read(3'd1, 0, "R8 agreement bit self-clears");
    idle(2);
    check("R9 no re-raise when idle", irq, 0);

    // simultaneous requests under full mask
    bus_write(3'd2, 32'hFF);
    src_in[5] = 1'b1;
    pulse(8'h06);
    idle(1);
    bus_write(3'd2, 32'h00);
    idle(1);
    check("R4 irq raised again", irq, 1);
    bus_read(3'd0, 2, "R5 tie goes to lower index");
    pulse(8'h08);
    idle(1);
    bus_read(3'd0, 2, "R10 source frozen");
    bus_read(3'd4, 32'h0A, "R2 pending during service");
    bus_write(3'd1, 1);
    check("R9 low first cycle", irq, 0);
    idle(1);
    check("R9 low second cycle", irq, 0);
    idle(1);
    check("R9 re-raised", irq, 1);
    bus_read(3'd0, 3, "R5 highest priority");
    bus_write(3'd1, 1);
    idle(2);
    bus_read(3'd0, 5, "R3 level line wins");
    bus_read(3'd4, 32'h02, "R3 level read leaves pending");
    src_in[5] = 1'b0;
    bus_write(3'd1, 1);
    idle(2);
    bus_read(3'd0, 1, "R5 last remaining");
    bus_write(3'd1, 1);
    idle(3);
    check("R9 stays low when drained", irq, 0);
    bus_read(3'd4, 0, "R7 all pending cleared");
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule